// File: doc/BRIEF.md
# Timing Reference Selector with Squelch

This block picks one timing reference for a network element out of several candidates: clocks recovered from Ethernet ports and clocks arriving on external synchronization inputs. Each candidate carries a received quality-level code from the synchronization status messages. The block monitors each candidate clock for activity. It ranks the usable candidates and drives a mux select toward the clock path. It asserts a squelch output when the chosen reference may not be passed downstream. When no line or external candidate is usable, the select points at the local oscillator, which sits at index `N_REFS`.

Activity is judged in fixed monitoring windows of the system clock. Each candidate clock is synchronized, and its rising edges are counted inside every window. The count must fall between a programmable minimum and maximum. A single bad window disqualifies a candidate at once. A disqualified candidate must then pass a programmable number of good windows before it may be chosen again, which gives the wait-to-restore behaviour. Quality codes map to ranks through a programmable table. Ties are settled by a programmable per-input priority and then by input index.

A three-state controller holds the selection:

- `ST_FREERUN`: nothing is usable; the local oscillator is selected and the output is squelched.
- `ST_LOCKED`: a usable reference at or above the threshold is selected.
- `ST_SQUELCH`: the best usable reference is selected but ranks below the threshold, so the output is squelched.

The controller has five transitions:

- ACQUIRE: `ST_FREERUN` to `ST_LOCKED`.
- ACQUIRE_LOW: `ST_FREERUN` to `ST_SQUELCH`.
- DEGRADE: `ST_LOCKED` to `ST_SQUELCH`.
- RECOVER: `ST_SQUELCH` to `ST_LOCKED`.
- LOSE: `ST_LOCKED` or `ST_SQUELCH` to `ST_FREERUN`.

Top module: `ref_selector`

## Requirements
- R1: A candidate is active only if its synchronized rising-edge count in a monitoring window of `WIN_LEN` system cycles lies in the inclusive range [`win_min_i`, `win_max_i`]. Candidates counting too few or too many edges are never selected.
- R2: One window whose count lies outside the range clears that candidate's activity at the end of that window. A selected candidate whose clock stops is deselected within two windows plus a few cycles.
- R3: After a failed window, a candidate becomes active again only after `wtr_i + 1` consecutive good windows.
- R4: The rank of a candidate is the 3-bit field at bits [3*q+2 : 3*q] of `rank_tbl_i`, where q is its 4-bit quality code taken from `ref_ql_i[4*i+3:4*i]`. Rank 0 excludes the candidate.
- R5: Quality code 4'hF means "do not use" and excludes the candidate whatever the table holds for it.
- R6: Among usable candidates, the one with the highest rank is selected.
- R7: On equal rank, the candidate with the lower 2-bit priority in `prio_i[2*i+1:2*i]` wins. On equal rank and equal priority, the lower index wins.
- R8: When no candidate is usable, `sel_o` equals `N_REFS` (the local oscillator) and `squelch_o` is 1.
- R9: With a usable candidate selected, `squelch_o` is 1 when its rank is below `sq_thr_i` and 0 when its rank is equal to or above it.
- R10: A change of quality code, table, priority or threshold is reflected on `sel_o` and `squelch_o` after one system clock edge.
- R11: During and right after reset, `sel_o` equals `N_REFS` and `squelch_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for monitoring and selection |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | N_REFS | Candidate reference clocks, sampled by the system clock |
| ref_ql_i | input | 4*N_REFS | Received quality code per candidate |
| rank_tbl_i | input | 48 | Rank per quality code, 3 bits per code |
| prio_i | input | 2*N_REFS | Tie-break priority per candidate, lower wins |
| win_min_i | input | 8 | Minimum edge count per window |
| win_max_i | input | 8 | Maximum edge count per window |
| wtr_i | input | 4 | Extra good windows required before restore |
| sq_thr_i | input | 3 | Lowest rank that is passed unsquelched |
| sel_o | output | 3 | Selected candidate; N_REFS means local oscillator |
| squelch_o | output | 1 | Selected output must not be used downstream |

## Verification
The embedded assertions check several properties on every cycle:

- An absence of usable candidates always leads to the local oscillator with squelch.
- Any selected candidate was usable and did not carry the do-not-use code in the previous cycle.
- A bad window always clears a candidate's activity.
- Activity only changes at window ends.

Other behaviours are shown only by the bench scenarios: the ranking order, the priority and index tie-breaks, the threshold boundary, the wait-to-restore count, and the speed of reselection after a clock stops. The bench compares these against a reference model over directed and random mixes of clock rates and quality codes.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
    localparam int QL_W     = 4;
    localparam int RANK_W   = 3;
    localparam int N_CODES  = 1 << QL_W;
    localparam int TBL_W    = N_CODES * RANK_W;
    localparam logic [QL_W-1:0] DNU_CODE = 4'hF;

    typedef enum logic [1:0] {
        ST_FREERUN = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_SQUELCH = 2'd2
    } sel_state_e;
endpackage

// File: rtl/ref_activity_mon.sv
module ref_activity_mon #(
    parameter int CNT_W = 8,
    parameter int WTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_i,
    input  logic             win_end_i,
    input  logic [CNT_W-1:0] win_min_i,
    input  logic [CNT_W-1:0] win_max_i,
    input  logic [WTR_W-1:0] wtr_i,
    output logic             valid_o
);
    logic [2:0]       sync_q;
    logic             rise;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_tot;
    logic [WTR_W-1:0] good_q;
    logic             win_good;

    assign rise     = sync_q[1] & ~sync_q[2];
    assign cnt_tot  = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + CNT_W'(rise);
    assign win_good = (cnt_tot >= win_min_i) && (cnt_tot <= win_max_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], ref_clk_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            good_q  <= '0;
            valid_o <= 1'b0;
        end else if (win_end_i) begin
            cnt_q <= '0;
            if (!win_good) begin
                valid_o <= 1'b0;
                good_q  <= '0;
            end else if (valid_o || good_q == wtr_i) begin
                valid_o <= 1'b1;
            end else begin
                good_q <= good_q + 1'b1;
            end
        end else begin
            cnt_q <= cnt_tot;
        end
    end

    // R2: a window outside limits clears activity at once
    a_r2_bad_window_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end_i && !win_good) |=> !valid_o);
    // R1: activity only changes at a window end
    a_r1_change_at_window: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end_i |=> $stable(valid_o));
endmodule

// File: rtl/ref_rank_arbiter.sv
module ref_rank_arbiter
    import ref_sel_pkg::*;
#(
    parameter int N_REFS = 4,
    parameter int PRIO_W = 2,
    parameter int SEL_W  = 3
) (
    input  logic [N_REFS-1:0]        valid_i,
    input  logic [N_REFS*QL_W-1:0]   ql_i,
    input  logic [TBL_W-1:0]         rank_tbl_i,
    input  logic [N_REFS*PRIO_W-1:0] prio_i,
    output logic [N_REFS-1:0]        usable_o,
    output logic                     found_o,
    output logic [SEL_W-1:0]         best_idx_o,
    output logic [RANK_W-1:0]        best_rank_o
);
    logic [RANK_W-1:0] rank_a [N_REFS];

    for (genvar g = 0; g < N_REFS; g++) begin : g_rank
        logic [QL_W-1:0] code;
        assign code      = ql_i[g*QL_W +: QL_W];
        assign rank_a[g] = (code == DNU_CODE) ? '0
                         : rank_tbl_i[int'(code)*RANK_W +: RANK_W];
        assign usable_o[g] = valid_i[g] && (rank_a[g] != '0);
    end

    always_comb begin
        logic [PRIO_W-1:0] best_prio;
        found_o     = 1'b0;
        best_idx_o  = '0;
        best_rank_o = '0;
        best_prio   = '1;
        for (int i = 0; i < N_REFS; i++) begin
            if (usable_o[i] &&
                (!found_o || rank_a[i] > best_rank_o ||
                 (rank_a[i] == best_rank_o &&
                  prio_i[i*PRIO_W +: PRIO_W] < best_prio))) begin
                found_o     = 1'b1;
                best_idx_o  = SEL_W'(i);
                best_rank_o = rank_a[i];
                best_prio   = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/ref_selector.sv
module ref_selector
    import ref_sel_pkg::*;
#(
    parameter int N_REFS  = 4,
    parameter int PRIO_W  = 2,
    parameter int CNT_W   = 8,
    parameter int WTR_W   = 4,
    parameter int WIN_LEN = 64,
    localparam int SEL_W  = $clog2(N_REFS + 1),
    localparam int WIN_W  = $clog2(WIN_LEN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_REFS-1:0]        ref_clk_i,
    input  logic [N_REFS*QL_W-1:0]   ref_ql_i,
    input  logic [TBL_W-1:0]         rank_tbl_i,
    input  logic [N_REFS*PRIO_W-1:0] prio_i,
    input  logic [CNT_W-1:0]         win_min_i,
    input  logic [CNT_W-1:0]         win_max_i,
    input  logic [WTR_W-1:0]         wtr_i,
    input  logic [RANK_W-1:0]        sq_thr_i,
    output logic [SEL_W-1:0]         sel_o,
    output logic                     squelch_o
);
    localparam logic [SEL_W-1:0] LO_SEL = SEL_W'(N_REFS);

    logic [WIN_W-1:0]  win_cnt_q;
    logic              win_end;
    logic [N_REFS-1:0] valid_w;
    logic [N_REFS-1:0] usable_w;
    logic              found_w;
    logic [SEL_W-1:0]  best_idx_w;
    logic [RANK_W-1:0] best_rank_w;
    sel_state_e        state_q, state_d;
    logic [SEL_W-1:0]  sel_q, sel_d;

    assign win_end = (win_cnt_q == WIN_W'(WIN_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt_q <= '0;
        end else if (win_end) begin
            win_cnt_q <= '0;
        end else begin
            win_cnt_q <= win_cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < N_REFS; g++) begin : g_mon
        ref_activity_mon #(.CNT_W(CNT_W), .WTR_W(WTR_W)) u_mon (
            .clk       (clk),
            .rst_n     (rst_n),
            .ref_clk_i (ref_clk_i[g]),
            .win_end_i (win_end),
            .win_min_i (win_min_i),
            .win_max_i (win_max_i),
            .wtr_i     (wtr_i),
            .valid_o   (valid_w[g])
        );
    end

    ref_rank_arbiter #(.N_REFS(N_REFS), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) u_arb (
        .valid_i     (valid_w),
        .ql_i        (ref_ql_i),
        .rank_tbl_i  (rank_tbl_i),
        .prio_i      (prio_i),
        .usable_o    (usable_w),
        .found_o     (found_w),
        .best_idx_o  (best_idx_w),
        .best_rank_o (best_rank_w)
    );

    // Next state: ACQUIRE, ACQUIRE_LOW, DEGRADE, RECOVER, LOSE
    always_comb begin
        state_d = state_q;
        sel_d   = found_w ? best_idx_w : LO_SEL;
        unique case (state_q)
            ST_FREERUN: begin
                if (found_w)
                    state_d = (best_rank_w >= sq_thr_i) ? ST_LOCKED : ST_SQUELCH;
            end
            ST_LOCKED: begin
                if (!found_w)                     state_d = ST_FREERUN;
                else if (best_rank_w < sq_thr_i)  state_d = ST_SQUELCH;
            end
            ST_SQUELCH: begin
                if (!found_w)                     state_d = ST_FREERUN;
                else if (best_rank_w >= sq_thr_i) state_d = ST_LOCKED;
            end
            default: state_d = ST_FREERUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREERUN;
            sel_q   <= LO_SEL;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        sel_o     = sel_q;
        squelch_o = (state_q != ST_LOCKED);
    end

    // R8: nothing usable leads to local oscillator and squelch
    a_r8_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        !(|usable_w) |=> (squelch_o && sel_o == LO_SEL));
    // R8: something usable means the local oscillator is not selected
    a_r8_no_lo_when_usable: assert property (@(posedge clk) disable iff (!rst_n)
        (|usable_w) |=> (sel_o != LO_SEL));

    for (genvar g = 0; g < N_REFS; g++) begin : g_chk
        // R6: a selected candidate was usable one cycle earlier
        a_r6_sel_usable: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_o == SEL_W'(g)) |-> $past(usable_w[g]));
        // R5: a selected candidate did not carry the do-not-use code
        a_r5_no_dnu: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_o == SEL_W'(g)) |-> ($past(ref_ql_i[g*QL_W +: QL_W]) != DNU_CODE));
    end
endmodule

// File: tb/ref_selector_test.sv
`timescale 1ns/1ps
module ref_selector_test;
    localparam int N   = 4;
    localparam int WIN = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ref_clk = '0;
    logic [15:0] ql_v = '0;
    logic [47:0] tbl_v = '0;
    logic [7:0]  prio_v = '0;
    logic [7:0]  wmin = 8'd12;
    logic [7:0]  wmax = 8'd20;
    logic [3:0]  wtr = 4'd2;
    logic [2:0]  thr = 3'd0;
    logic [2:0]  sel;
    logic        squelch;

    int half [4];
    int ph [4];
    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ref_selector uut (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .ref_ql_i(ql_v),
        .rank_tbl_i(tbl_v), .prio_i(prio_v), .win_min_i(wmin), .win_max_i(wmax),
        .wtr_i(wtr), .sq_thr_i(thr), .sel_o(sel), .squelch_o(squelch)
    );

    // candidate clock generators: half period in system cycles, 0 = stopped
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (half[i] == 0) begin
                ref_clk[i] = 1'b0;
                ph[i] = 0;
            end else if (ph[i] + 1 >= half[i]) begin
                ref_clk[i] = ~ref_clk[i];
                ph[i] = 0;
            end else begin
                ph[i] = ph[i] + 1;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rank_of(int q);
        if (q == 15) return 0;
        return int'(tbl_v[q*3 +: 3]);
    endfunction

    // model: returns {squelch, sel}
    function automatic int model();
        int best = -1;
        int br = 0;
        int bp = 0;
        for (int i = 0; i < N; i++) begin
            int r = rank_of(int'(ql_v[i*4 +: 4]));
            int p = int'(prio_v[i*2 +: 2]);
            if (half[i] == 2 && r != 0 &&
                (best < 0 || r > br || (r == br && p < bp))) begin
                best = i; br = r; bp = p;
            end
        end
        if (best < 0) return 8 + N;
        return ((br < int'(thr)) ? 8 : 0) + best;
    endfunction

    task automatic check_model(string req);
        int m = model();
        chk({req, " sel"}, int'(sel), m % 8);
        chk({req, " squelch"}, int'(squelch), m / 8);
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        cyc((int'(wtr) + 4) * WIN);
    endtask

    task automatic set_ql(int a, int b, int c, int d);
        ql_v = {4'(d), 4'(c), 4'(b), 4'(a)};
    endtask

    task automatic set_half(int a, int b, int c, int d);
        half[0] = a; half[1] = b; half[2] = c; half[3] = d;
    endtask

    function automatic int pick_half(int r);
        case (r)
            3: return 0;
            4: return 1;
            5: return 8;
            default: return 2;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired (all requirements)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd715));
        for (int q = 0; q < 16; q++)
            tbl_v[q*3 +: 3] = (q == 15) ? 3'd7 : (q < 8 ? 3'(q) : 3'd0);
        set_half(0, 0, 0, 0);
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R11: reset state
        chk("R11 sel", int'(sel), N);
        chk("R11 squelch", int'(squelch), 1);

        // R8: all stopped
        settle();
        chk("R8 sel", int'(sel), N);
        chk("R8 squelch", int'(squelch), 1);

        // R6: highest rank
        set_half(2, 2, 2, 2);
        set_ql(1, 5, 3, 2);
        settle();
        chk("R6 sel", int'(sel), 1);
        chk("R6 squelch", int'(squelch), 0);

        // R7: priority then index tie-break
        set_ql(5, 5, 5, 5);
        prio_v = {2'd2, 2'd1, 2'd1, 2'd3};
        cyc(2);
        chk("R7 prio", int'(sel), 1);
        prio_v = '0;
        cyc(2);
        chk("R7 index", int'(sel), 0);

        // R4, R5: rank 0 and do-not-use excluded
        set_ql(0, 0, 15, 0);
        cyc(2);
        chk("R4 R5 sel", int'(sel), N);
        chk("R4 R5 squelch", int'(squelch), 1);
        set_ql(0, 2, 15, 0);
        cyc(2);
        chk("R4 sel", int'(sel), 1);

        // R9: threshold boundary
        set_ql(3, 0, 0, 0);
        thr = 3'd4;
        cyc(2);
        chk("R9 below sel", int'(sel), 0);
        chk("R9 below squelch", int'(squelch), 1);
        thr = 3'd3;
        cyc(2);
        chk("R9 equal squelch", int'(squelch), 0);
        thr = 3'd0;

        // R1: too fast and too slow excluded
        set_ql(6, 4, 0, 0);
        set_half(1, 2, 2, 2);
        settle();
        chk("R1 fast", int'(sel), 1);
        half[0] = 8;
        settle();
        chk("R1 slow", int'(sel), 1);
        half[0] = 2;
        settle();
        chk("R1 good", int'(sel), 0);

        // R2: fast reselection after clock stop
        half[0] = 0;
        cyc(2 * WIN + 10);
        chk("R2 reselect", int'(sel), 1);

        // R3: wait-to-restore
        wtr = 4'd5;
        cyc(2 * WIN);
        half[0] = 2;
        cyc(3 * WIN);
        chk("R3 held off", int'(sel), 1);
        cyc(7 * WIN);
        chk("R3 restored", int'(sel), 0);
        wtr = 4'd2;

        // R10: quality change seen after one edge
        set_ql(3, 4, 0, 0);
        cyc(2);
        chk("R10 sel", int'(sel), 1);

        // random mix (R6 R7 R8 R9)
        for (int it = 0; it < 40; it++) begin
            for (int i = 0; i < N; i++) begin
                half[i] = pick_half(int'($urandom % 6));
                ql_v[i*4 +: 4] = 4'($urandom % 16);
                prio_v[i*2 +: 2] = 2'($urandom % 4);
            end
            thr = 3'($urandom % 8);
            settle();
            check_model("R6 R7 R8 R9 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule